// File: doc/BRIEF.md
# Stateful Implication Logic Sequencer

This block computes Boolean results without combinational gates on its operands. A small bank of one-bit storage cells acts as both memory and compute element. Only two in-place primitives can change a cell: SET, which forces a cell to 1, and NIMP, which rewrites a target cell as `target AND (NOT source)` and leaves the source cell alone. Because SET and NIMP together form a complete basis, any Boolean function can be built by chaining them. Every intermediate value stays in its cell, so each step works on what the step before left behind.

A sequencer takes a command (NOR or NAND), a result-cell index and two operand-cell indices. It issues one primitive per clock, shows each step on a debug output, and pulses `done` once the result cell holds the answer. NOR takes three steps. NAND takes five, and it overwrites the second operand cell with the AND of both operands. That side effect is flagged alongside `done`. A command whose result cell is the same as either operand cell is refused.

A direct primitive port lets a testbench load cells, or apply a single SET or NIMP. A combinational read port exposes any cell.

Top module: `imp_seq_top`

## Requirements
- R1: After a synchronous active-low reset, every cell reads 0, `busy`, `done`, `reject` and `opc_clobbered` are 0, `dbg_step` is 0 and `dbg_prim` is 0 (none).
- R2: A direct NIMP (`dir_cmd` = 2) sets cell `dir_tgt` to `tgt AND NOT src` at the next clock edge. Cell `dir_src` keeps its value. With the same index for both, the cell becomes 0.
- R3: A direct SET (`dir_cmd` = 1) writes 1 into cell `dir_tgt`. A direct LOAD (`dir_cmd` = 3) writes `dir_data` into cell `dir_tgt`. `dir_cmd` = 0 does nothing.
- R4: A NOR command (`op` = 0) runs exactly three steps, one per clock: SET a; NIMP target a, source b; NIMP target a, source c. During each step `dbg_step` shows 1, 2, 3 and `dbg_prim` shows the primitive (1 = SET, 2 = NIMP). Afterwards cell a holds b NOR c.
- R5: A NAND command (`op` = 1) runs exactly five steps: SET a; NIMP a←b; NIMP target c, source a; SET a; NIMP a←c. Afterwards cell a holds b NAND c and cell c holds b AND c.
- R6: `busy` is high for exactly the step cycles. `done` is a one-cycle pulse in the cycle after the last step edge, with `busy` low. `opc_clobbered` pulses with `done` only for NAND.
- R7: While `busy` is high, `start` and the direct port are ignored.
- R8: A `start` whose result index equals either operand index gives a one-cycle `reject` pulse, no steps, and no cell change.
- R9: Cells that a command does not name keep their values.
- R10: If a direct command and an accepted `start` fall in the same cycle, the direct command takes effect at that edge and the first step reads its result.
- R11: `rd_data` always shows the current value of cell `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a command |
| op | input | 1 | 0 = NOR, 1 = NAND |
| res_idx | input | 3 | Result cell a |
| opb_idx | input | 3 | First operand cell b |
| opc_idx | input | 3 | Second operand cell c |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result ready pulse |
| reject | output | 1 | Command refused pulse |
| opc_clobbered | output | 1 | Operand c was overwritten (NAND) |
| dir_cmd | input | 2 | Direct primitive: 0 none, 1 SET, 2 NIMP, 3 LOAD |
| dir_tgt | input | 3 | Direct target cell |
| dir_src | input | 3 | Direct source cell |
| dir_data | input | 1 | Value for LOAD |
| rd_idx | input | 3 | Read select |
| rd_data | output | 1 | Selected cell value |
| dbg_step | output | 3 | Current step number, 0 when idle |
| dbg_prim | output | 2 | Current primitive: 0 none, 1 SET, 2 NIMP |

## Verification
Two functions can land on the same clock edge: a direct primitive and an accepted command start. The bench provokes this by loading an operand cell in the same cycle as a NOR start. The check passes only if the result reflects the freshly loaded value, which shows the direct write landed first. The bench also overlaps a second start and a direct load with a running NAND, and judges that neither one leaves a trace in any cell or in the step trace. A behavioural model built on a step queue is compared with the outputs on every clock.

// File: rtl/imp_pkg.sv
// Shared types for the implication logic sequencer.
// Assumes step numbers fit in three bits (longest command is five steps).
package imp_pkg;

    typedef enum logic [1:0] {
        PR_NONE = 2'd0,
        PR_SET  = 2'd1,
        PR_NIMP = 2'd2,
        PR_LOAD = 2'd3
    } prim_e;

    typedef enum logic {
        CMD_NOR  = 1'b0,
        CMD_NAND = 1'b1
    } cmd_e;

    typedef enum logic [1:0] {
        ROLE_A = 2'd0,
        ROLE_B = 2'd1,
        ROLE_C = 2'd2
    } role_e;

    typedef struct packed {
        prim_e prim;
        role_e tgt;
        role_e src;
    } step_t;

    localparam int STEP_W = 3;
    localparam logic [STEP_W-1:0] NOR_LAST  = 3'd3;
    localparam logic [STEP_W-1:0] NAND_LAST = 3'd5;

    // Primitive issued at a given 1-based step of a command.
    function automatic step_t step_of(cmd_e cmd, logic [STEP_W-1:0] n);
        step_t s;
        s = '{prim: PR_NONE, tgt: ROLE_A, src: ROLE_A};
        if (cmd == CMD_NOR) begin
            case (n)
                3'd1:    s = '{prim: PR_SET,  tgt: ROLE_A, src: ROLE_A};
                3'd2:    s = '{prim: PR_NIMP, tgt: ROLE_A, src: ROLE_B};
                3'd3:    s = '{prim: PR_NIMP, tgt: ROLE_A, src: ROLE_C};
                default: s = '{prim: PR_NONE, tgt: ROLE_A, src: ROLE_A};
            endcase
        end else begin
            case (n)
                3'd1:    s = '{prim: PR_SET,  tgt: ROLE_A, src: ROLE_A};
                3'd2:    s = '{prim: PR_NIMP, tgt: ROLE_A, src: ROLE_B};
                3'd3:    s = '{prim: PR_NIMP, tgt: ROLE_C, src: ROLE_A};
                3'd4:    s = '{prim: PR_SET,  tgt: ROLE_A, src: ROLE_A};
                3'd5:    s = '{prim: PR_NIMP, tgt: ROLE_A, src: ROLE_C};
                default: s = '{prim: PR_NONE, tgt: ROLE_A, src: ROLE_A};
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/imp_cell_array.sv
// Bank of one-bit stateful cells. Applies at most one primitive per clock
// to the addressed target cell; all other cells hold.
// Assumes: the primitive inputs are already arbitrated; reset is synchronous
// and active-low; indices at or above NUM_CELLS address no cell.
module imp_cell_array
    import imp_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  prim_e            prim,
    input  logic [IDX_W-1:0] tgt,
    input  logic [IDX_W-1:0] src,
    input  logic             data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_data
);

    logic [NUM_CELLS-1:0] cells_q;
    logic                 src_val;

    // Source value as seen before this edge's update.
    assign src_val = cells_q[src];

    // Combinational read port.
    assign rd_data = cells_q[rd_idx];

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
        // Per-cell update: only the selected target reacts to a primitive.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells_q[gi] <= 1'b0;
            end else if (tgt == IDX_W'(gi)) begin
                case (prim)
                    PR_SET:  cells_q[gi] <= 1'b1;
                    PR_NIMP: cells_q[gi] <= cells_q[gi] & ~src_val;
                    PR_LOAD: cells_q[gi] <= data;
                    default: cells_q[gi] <= cells_q[gi];
                endcase
            end
        end
    end

    // R2: the source cell of a NIMP keeps its value.
    p_src_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prim == PR_NIMP && tgt != src) |=> cells_q[$past(src)] == $past(src_val));

    // R2: NIMP can only clear a cell, never raise it.
    p_nimp_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prim == PR_NIMP && !cells_q[tgt]) |=> !cells_q[$past(tgt)]);

    // R3: SET leaves a 1 in its target.
    p_set_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prim == PR_SET) |=> cells_q[$past(tgt)]);

    // R9: with no primitive, the whole bank holds.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prim == PR_NONE) |=> $stable(cells_q));

endmodule

// File: rtl/imp_seq_ctrl.sv
// Command sequencer. Accepts NOR/NAND with three cell indices, refuses
// commands whose result cell overlaps an operand, then walks the step
// table one step per clock and pulses done after the last step.
// Assumes: start is sampled only while idle.
module imp_seq_ctrl
    import imp_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_e              cmd,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [IDX_W-1:0]  c_idx,
    output logic              busy,
    output logic              done,
    output logic              reject,
    output logic              clobbered,
    output logic [STEP_W-1:0] step_no,
    output prim_e             prim,
    output logic [IDX_W-1:0]  tgt,
    output logic [IDX_W-1:0]  src
);

    logic              busy_q, done_q, reject_q, clob_q;
    cmd_e              cmd_q;
    logic [IDX_W-1:0]  a_q, b_q, c_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last_step;
    logic              overlap;
    step_t             cur;

    // Final step number for the latched command.
    assign last_step = (cmd_q == CMD_NAND) ? NAND_LAST : NOR_LAST;

    // A result cell may not double as an operand cell.
    assign overlap = (a_idx == b_idx) || (a_idx == c_idx);

    // Command and step state: accept, advance, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            clob_q   <= 1'b0;
            cmd_q    <= CMD_NOR;
            a_q      <= '0;
            b_q      <= '0;
            c_q      <= '0;
            step_q   <= '0;
        end else begin
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            clob_q   <= 1'b0;
            if (busy_q) begin
                if (step_q == last_step) begin
                    busy_q <= 1'b0;
                    step_q <= '0;
                    done_q <= 1'b1;
                    clob_q <= (cmd_q == CMD_NAND);
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else if (start) begin
                if (overlap) begin
                    reject_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    step_q <= 3'd1;
                    cmd_q  <= cmd;
                    a_q    <= a_idx;
                    b_q    <= b_idx;
                    c_q    <= c_idx;
                end
            end
        end
    end

    // Decode the current step into a primitive on concrete cell indices.
    always_comb begin
        cur = busy_q ? step_of(cmd_q, step_q) : '{prim: PR_NONE, tgt: ROLE_A, src: ROLE_A};
        prim = cur.prim;
        case (cur.tgt)
            ROLE_B:  tgt = b_q;
            ROLE_C:  tgt = c_q;
            default: tgt = a_q;
        endcase
        case (cur.src)
            ROLE_B:  src = b_q;
            ROLE_C:  src = c_q;
            default: src = a_q;
        endcase
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign reject    = reject_q;
    assign clobbered = clob_q;
    assign step_no   = step_q;

    // R6: done lasts one cycle and never overlaps busy.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: steps run 1..3 for NOR; R5: 1..5 for NAND.
    p_nor_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_q == CMD_NOR) |-> (step_no >= 3'd1 && step_no <= NOR_LAST));
    p_nand_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_q == CMD_NAND) |-> (step_no >= 3'd1 && step_no <= NAND_LAST));

    // R7: operands stay latched for the whole sequence.
    p_hold_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q) && $stable(c_q)));

    // R8: a refused command never starts a sequence.
    p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy);

endmodule

// File: rtl/imp_prim_arb.sv
// Chooses which primitive reaches the cell bank: the sequencer while it
// runs, otherwise the direct port. Purely combinational.
// Assumes: the sequencer reports PR_NONE whenever it is idle.
module imp_prim_arb
    import imp_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic             seq_busy,
    input  prim_e            seq_prim,
    input  logic [IDX_W-1:0] seq_tgt,
    input  logic [IDX_W-1:0] seq_src,
    input  prim_e            dir_prim,
    input  logic [IDX_W-1:0] dir_tgt,
    input  logic [IDX_W-1:0] dir_src,
    input  logic             dir_data,
    output prim_e            prim,
    output logic [IDX_W-1:0] tgt,
    output logic [IDX_W-1:0] src,
    output logic             data
);

    // Sequencer owns the bank while busy; direct port is shut out.
    always_comb begin
        if (seq_busy) begin
            prim = seq_prim;
            tgt  = seq_tgt;
            src  = seq_src;
            data = 1'b0;
        end else begin
            prim = dir_prim;
            tgt  = dir_tgt;
            src  = dir_src;
            data = dir_data;
        end
    end

endmodule

// File: rtl/imp_seq_top.sv
// Top of the stateful implication logic sequencer: cell bank, command
// sequencer and primitive arbiter.
// Assumes: synchronous active-low reset; eight cells by default.
module imp_seq_top
    import imp_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int IDX_W = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [IDX_W-1:0]  opb_idx,
    input  logic [IDX_W-1:0]  opc_idx,
    output logic              busy,
    output logic              done,
    output logic              reject,
    output logic              opc_clobbered,
    input  logic [1:0]        dir_cmd,
    input  logic [IDX_W-1:0]  dir_tgt,
    input  logic [IDX_W-1:0]  dir_src,
    input  logic              dir_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_data,
    output logic [STEP_W-1:0] dbg_step,
    output logic [1:0]        dbg_prim
);

    prim_e            seq_prim, bank_prim;
    logic [IDX_W-1:0] seq_tgt, seq_src, bank_tgt, bank_src;
    logic             bank_data;

    imp_seq_ctrl #(.NUM_CELLS(NUM_CELLS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd_e'(op)),
        .a_idx     (res_idx),
        .b_idx     (opb_idx),
        .c_idx     (opc_idx),
        .busy      (busy),
        .done      (done),
        .reject    (reject),
        .clobbered (opc_clobbered),
        .step_no   (dbg_step),
        .prim      (seq_prim),
        .tgt       (seq_tgt),
        .src       (seq_src)
    );

    imp_prim_arb #(.NUM_CELLS(NUM_CELLS)) u_arb (
        .seq_busy (busy),
        .seq_prim (seq_prim),
        .seq_tgt  (seq_tgt),
        .seq_src  (seq_src),
        .dir_prim (prim_e'(dir_cmd)),
        .dir_tgt  (dir_tgt),
        .dir_src  (dir_src),
        .dir_data (dir_data),
        .prim     (bank_prim),
        .tgt      (bank_tgt),
        .src      (bank_src),
        .data     (bank_data)
    );

    imp_cell_array #(.NUM_CELLS(NUM_CELLS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .prim    (bank_prim),
        .tgt     (bank_tgt),
        .src     (bank_src),
        .data    (bank_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Debug view of the primitive being applied this cycle.
    assign dbg_prim = seq_prim;

    // R7: the direct port never reaches the bank while a sequence runs.
    p_dir_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bank_prim == seq_prim));

endmodule

// File: tb/imp_seq_top_tb_top.sv
module imp_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op = 1'b0;
    logic [2:0] res_idx = '0, opb_idx = '0, opc_idx = '0;
    logic       busy, done, reject, opc_clobbered;
    logic [1:0] dir_cmd = '0;
    logic [2:0] dir_tgt = '0, dir_src = '0;
    logic       dir_data = 1'b0;
    logic [2:0] rd_idx = '0;
    logic       rd_data;
    logic [2:0] dbg_step;
    logic [1:0] dbg_prim;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    imp_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .res_idx(res_idx), .opb_idx(opb_idx), .opc_idx(opc_idx),
        .busy(busy), .done(done), .reject(reject), .opc_clobbered(opc_clobbered),
        .dir_cmd(dir_cmd), .dir_tgt(dir_tgt), .dir_src(dir_src), .dir_data(dir_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .dbg_step(dbg_step), .dbg_prim(dbg_prim)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct { int prim; int tgt; int src; } mstep_t;
    mstep_t m_q[$];
    bit     m_cell[8];
    bit     m_done, m_rej, m_clob, m_nand;
    int     m_step;

    function automatic void m_apply(int p, int t, int s, bit d);
        if (p == 1) m_cell[t] = 1'b1;
        else if (p == 2) m_cell[t] = m_cell[t] & !m_cell[s];
        else if (p == 3) m_cell[t] = d;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cell[i]) m_cell[i] = 1'b0;
            m_q.delete();
            m_done = 0; m_rej = 0; m_clob = 0; m_step = 0; m_nand = 0;
        end else begin
            m_done = 0; m_rej = 0; m_clob = 0;
            if (m_q.size() > 0) begin
                m_apply(m_q[0].prim, m_q[0].tgt, m_q[0].src, 1'b0);
                void'(m_q.pop_front());
                m_step++;
                if (m_q.size() == 0) begin
                    m_done = 1; m_clob = m_nand; m_step = 0;
                end
            end else begin
                m_apply(int'(dir_cmd), int'(dir_tgt), int'(dir_src), dir_data);
                if (start) begin
                    if (res_idx == opb_idx || res_idx == opc_idx) m_rej = 1;
                    else begin
                        int a, b, c;
                        a = res_idx; b = opb_idx; c = opc_idx;
                        m_nand = op;
                        m_q.push_back('{1, a, a});
                        m_q.push_back('{2, a, b});
                        if (op) begin
                            m_q.push_back('{2, c, a});
                            m_q.push_back('{1, a, a});
                        end
                        m_q.push_back('{2, a, c});
                        m_step = 1;
                    end
                end
            end
        end
        #5;
        // Per-clock comparison (R1, R4, R5, R6, R8, R11).
        check(busy == (m_q.size() > 0), "R6 busy", busy, m_q.size() > 0);
        check(done == m_done, "R6 done", done, m_done);
        check(opc_clobbered == m_clob, "R6 opc_clobbered", opc_clobbered, m_clob);
        check(reject == m_rej, "R8 reject", reject, m_rej);
        check(int'(dbg_step) == m_step, "R4 dbg_step", dbg_step, m_step);
        check(int'(dbg_prim) == ((m_q.size() > 0) ? m_q[0].prim : 0), "R5 dbg_prim",
              dbg_prim, (m_q.size() > 0) ? m_q[0].prim : 0);
        check(rd_data == m_cell[rd_idx], "R11 rd_data", rd_data, m_cell[rd_idx]);
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic dir(input logic [1:0] c, input int t, input int s, input bit d);
        dir_cmd = c; dir_tgt = 3'(t); dir_src = 3'(s); dir_data = d;
        @(negedge clk);
        dir_cmd = 2'd0;
    endtask

    task automatic run(input bit o, input int a, input int b, input int c);
        start = 1'b1; op = o; res_idx = 3'(a); opb_idx = 3'(b); opc_idx = 3'(c);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd(input int idx, input bit exp, input string tag);
        rd_idx = 3'(idx);
        #1;
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    // Watchdog: a hang is a failed check and still ends with the summary.
    initial begin
        #(20 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        bit pat[8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 8; i++) rd(i, 1'b0, "R1 reset cell");
        check(busy == 0 && done == 0 && dbg_step == 0, "R1 reset flags", busy, 0);

        // R3: LOAD and SET
        dir(2'd3, 4, 0, 1'b1); rd(4, 1'b1, "R3 load 1");
        dir(2'd3, 4, 0, 1'b0); rd(4, 1'b0, "R3 load 0");
        dir(2'd1, 4, 0, 1'b0); rd(4, 1'b1, "R3 set");
        dir(2'd0, 4, 0, 1'b0); rd(4, 1'b1, "R3 none");

        // R2: NIMP truth table, source kept
        for (int v = 0; v < 4; v++) begin
            bit s, t;
            s = v[1]; t = v[0];
            dir(2'd3, 1, 0, s); dir(2'd3, 2, 0, t);
            dir(2'd2, 2, 1, 1'b0);
            rd(2, t & !s, "R2 nimp target");
            rd(1, s, "R2 nimp source");
        end
        dir(2'd3, 3, 0, 1'b1); dir(2'd2, 3, 3, 1'b0); rd(3, 1'b0, "R2 self nimp");

        // R4/R9: NOR with a=0,b=1,c=2; cells 3..7 preset
        for (int i = 3; i < 8; i++) begin pat[i] = (i % 2); dir(2'd3, i, 0, pat[i]); end
        for (int v = 0; v < 4; v++) begin
            bit vb, vc;
            vb = v[1]; vc = v[0];
            dir(2'd3, 1, 0, vb); dir(2'd3, 2, 0, vc); dir(2'd3, 0, 0, 1'b0);
            run(1'b0, 0, 1, 2);
            rd(0, !(vb | vc), "R4 nor result");
            rd(1, vb, "R9 nor b kept");
            rd(2, vc, "R9 nor c kept");
        end
        for (int i = 3; i < 8; i++) rd(i, pat[i], "R9 nor bystander");

        // R5/R9: NAND with a=5,b=6,c=7
        for (int i = 0; i < 5; i++) begin pat[i] = (i % 2 == 0); dir(2'd3, i, 0, pat[i]); end
        for (int v = 0; v < 4; v++) begin
            bit vb, vc;
            vb = v[1]; vc = v[0];
            dir(2'd3, 6, 0, vb); dir(2'd3, 7, 0, vc);
            run(1'b1, 5, 6, 7);
            rd(5, !(vb & vc), "R5 nand result");
            rd(7, vb & vc, "R5 nand c clobbered");
            rd(6, vb, "R9 nand b kept");
        end
        for (int i = 0; i < 5; i++) rd(i, pat[i], "R9 nand bystander");

        // R7: start and direct load during a running NAND are ignored
        dir(2'd3, 6, 0, 1'b1); dir(2'd3, 7, 0, 1'b1); dir(2'd3, 0, 0, 1'b1);
        dir(2'd3, 3, 0, 1'b1);
        start = 1'b1; op = 1'b1; res_idx = 3'd5; opb_idx = 3'd6; opc_idx = 3'd7;
        @(negedge clk);
        start = 1'b1; op = 1'b0; res_idx = 3'd3; opb_idx = 3'd1; opc_idx = 3'd2;
        dir_cmd = 2'd3; dir_tgt = 3'd0; dir_data = 1'b0;
        @(negedge clk);
        start = 1'b0; dir_cmd = 2'd0;
        repeat (6) @(negedge clk);
        rd(0, 1'b1, "R7 direct ignored while busy");
        rd(3, 1'b1, "R7 start ignored while busy");
        rd(5, 1'b0, "R7 first nand intact");

        // R8: overlap refused
        dir(2'd3, 2, 0, 1'b1);
        start = 1'b1; op = 1'b0; res_idx = 3'd2; opb_idx = 3'd2; opc_idx = 3'd4;
        @(posedge clk); #5;
        check(reject == 1 && busy == 0, "R8 reject pulse", reject, 1);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rd(2, 1'b1, "R8 no cell change");

        // R10: direct load and start in the same cycle
        dir(2'd3, 1, 0, 1'b0); dir(2'd3, 2, 0, 1'b0);
        dir_cmd = 2'd3; dir_tgt = 3'd1; dir_data = 1'b1;
        start = 1'b1; op = 1'b0; res_idx = 3'd0; opb_idx = 3'd1; opc_idx = 3'd2;
        @(negedge clk);
        start = 1'b0; dir_cmd = 2'd0;
        repeat (6) @(negedge clk);
        rd(0, 1'b0, "R10 same-cycle load seen");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule